// File: doc/BRIEF.md
# Vector Priority Interrupt Arbiter

This block decides which interrupt vector a processor core should take next. It keeps two 256-bit bitmaps indexed by the 8-bit vector number. One holds requests that are waiting. The other holds interrupts that have been taken and are not yet retired. The priority class of a vector is its upper nibble, and vectors 0 through 31 are reserved.

The arbiter raises its interrupt line only when the best waiting class beats two limits: the class in the task-priority register and the class of the highest in-service vector. On an acknowledge pulse it hands back the chosen vector and moves it from pending to in-service. If nothing qualifies, it hands back a programmable spurious vector instead. Software retires the current interrupt by writing the end-of-interrupt register. A 32-bit register port gives access to the task-priority, end-of-interrupt and spurious/enable registers and to the eight in-service words.

Top module: `vector_priority_arbiter`

## Requirements
- R1: After reset, the following hold:
  - both bitmaps are empty and the software enable is 0;
  - the spurious/enable register reads 0x000000FF;
  - the task-priority register reads 0;
  - `intOut` is low.
- R2: `reqReady` is always 1. A request on `reqVector` is recorded as pending only when `reqValid` is high, the vector is 32 to 255, and the software enable is 1. Otherwise it is dropped.
- R3: The class of a vector is bits 7:4 of the vector. `intOut` is high exactly when all of these hold:
  - the enable is 1;
  - a request is pending;
  - the class of the highest pending vector is strictly greater than the task-priority class;
  - that class is strictly greater than the class of the highest in-service vector, or nothing is in service.
- R4: The task-priority register sits at offset 0x080. Its class is bits 7:4 of the register, and bits 7:0 read back as written. A class of 15 keeps `intOut` low whatever is pending.
- R5: Suppose `ackReq` is high while `intOut` is high. On the following cycle `ackDone` is high and `ackVector` carries the highest-numbered pending vector. That vector's pending bit clears and its in-service bit sets.
- R6: Suppose `ackReq` is high while `intOut` is low. On the following cycle `ackDone` is high and `ackVector` carries bits 7:0 of the spurious/enable register. Neither bitmap changes.
- R7: A write to offset 0x0B0 (end-of-interrupt) clears only the highest set in-service bit, whatever the write data. With nothing in service, it has no effect.
- R8: In-service word n (n = 0..7) is read at offset 0x100 + 0x10·n. Bit i of word n is vector 32·n + i. Read data appears on `regRdData` in the cycle after `regRdEn`, and unmapped offsets read 0.
- R9: The spurious/enable register sits at offset 0x0F0 with this layout:
  - bits 7:0 hold the spurious vector;
  - bit 8 is the software enable;
  - bit 9 is a focus-check disable that is stored and read back only;
  - the other bits read 0.

  Clearing the enable drops `intOut` at once. Pending requests are kept and become deliverable again when the enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Vector request valid |
| reqVector | input | 8 | Requested vector |
| reqReady | output | 1 | Request accepted (always 1) |
| intOut | output | 1 | Interrupt to the processor |
| ackReq | input | 1 | Acknowledge pulse from the processor |
| ackDone | output | 1 | Acknowledge answer valid |
| ackVector | output | 8 | Delivered or spurious vector |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 12 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Registered read data |

## Verification
The bench targets these corner cases:
- **Equal classes.** It waits for a request whose class equals the task-priority or in-service class and checks that no interrupt is raised. A design comparing with `>=` would nest an interrupt inside its own class.
- **Acknowledge with nothing eligible.** It acknowledges when the threshold is 15, after the enable is cleared, and with only reserved vectors requested. A faulty design would hand out a real vector or set a stray in-service bit instead of returning the spurious vector.
- **End-of-interrupt.** It issues end-of-interrupt writes with two interrupts nested and with nothing in service. A design that cleared the whole bitmap or the lowest bit would unmask the wrong level.
- **Same-class choice.** It checks that the higher vector of two in one class wins.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
  localparam int VEC_W     = 8;
  localparam int NUM_VEC   = 1 << VEC_W;
  localparam int CLASS_W   = 4;
  localparam int FIRST_VEC = 32;

  typedef logic [VEC_W-1:0]   vec_t;
  typedef logic [CLASS_W-1:0] class_t;

  // strobes from control to datapath
  typedef struct packed {
    logic setReq;
    vec_t setVec;
    logic ackTake;
    logic eoiClear;
  } vpa_strobe_t;

  function automatic class_t classOf(vec_t v);
    return v[VEC_W-1 -: CLASS_W];
  endfunction
endpackage

// File: rtl/vpa_prio_enc.sv
module vpa_prio_enc #(
  parameter int N = 256,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     bits,
  output logic [IDX_W-1:0] idx,
  output logic             found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vpa_datapath.sv
module vpa_datapath
  import vpa_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  vpa_strobe_t        strobe,
  output vec_t               hpVec,
  output logic               hpValid,
  output vec_t               isVec,
  output logic               isValid,
  output logic [NUM_VEC-1:0] isrBits
);
  logic [NUM_VEC-1:0] irr, isr;
  logic [NUM_VEC-1:0] setMask, takeMask, eoiMask;

  vpa_prio_enc #(.N(NUM_VEC)) u_pendEnc (.bits(irr), .idx(hpVec), .found(hpValid));
  vpa_prio_enc #(.N(NUM_VEC)) u_svcEnc  (.bits(isr), .idx(isVec), .found(isValid));

  always_comb begin
    setMask  = '0;
    takeMask = '0;
    eoiMask  = '0;
    if (strobe.setReq)   setMask[strobe.setVec] = 1'b1;
    if (strobe.ackTake)  takeMask[hpVec]        = 1'b1;
    if (strobe.eoiClear) eoiMask[isVec]         = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irr <= '0;
      isr <= '0;
    end else begin
      irr <= (irr & ~takeMask) | setMask;
      isr <= (isr & ~eoiMask) | takeMask;
    end
  end

  assign isrBits = isr;

  // R2
  reserved_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    irr[FIRST_VEC-1:0] == '0);
  // R5
  ack_insvc_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackTake |=> isr[$past(hpVec)]);
  // R7
  eoi_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.eoiClear && !strobe.ackTake |=> $countones(isr) == $countones($past(isr)) - 1);
endmodule

// File: rtl/vpa_control.sv
module vpa_control
  import vpa_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int ADDR_W     = 12,
  parameter int TPR_OFS    = 'h080,
  parameter int EOI_OFS    = 'h0B0,
  parameter int SVR_OFS    = 'h0F0,
  parameter int ISR_OFS    = 'h100,
  parameter int ISR_STRIDE = 'h10,
  localparam int NUM_WORDS = NUM_VEC / REG_W,
  localparam int SVR_BITS  = VEC_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  vec_t               reqVector,
  input  logic               ackReq,
  output logic               ackDone,
  output vec_t               ackVector,
  output logic               intOut,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  vec_t               hpVec,
  input  logic               hpValid,
  input  vec_t               isVec,
  input  logic               isValid,
  input  logic [NUM_VEC-1:0] isrBits,
  output vpa_strobe_t        strobe
);
  logic [VEC_W-1:0]    tprReg;
  logic [SVR_BITS-1:0] svrReg;
  logic                swEnable;
  vec_t                spurVec;
  logic                eligible;
  logic                unusedWrBits;
  logic [REG_W-1:0]    isrWord [NUM_WORDS];
  logic [REG_W-1:0]    rdMux;

  assign swEnable     = svrReg[VEC_W];
  assign spurVec      = svrReg[VEC_W-1:0];
  assign unusedWrBits = ^regWrData[REG_W-1:SVR_BITS];

  assign eligible = swEnable && hpValid
                 && (classOf(hpVec) > tprReg[VEC_W-1 -: CLASS_W])
                 && (!isValid || classOf(hpVec) > classOf(isVec));
  assign intOut = eligible;

  always_comb begin
    strobe.setReq   = reqValid && swEnable && (reqVector >= vec_t'(FIRST_VEC));
    strobe.setVec   = reqVector;
    strobe.ackTake  = ackReq && eligible;
    strobe.eoiClear = regWrEn && (regAddr == ADDR_W'(EOI_OFS)) && isValid;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_isrWord
    assign isrWord[w] = isrBits[w*REG_W +: REG_W];
  end

  always_comb begin
    rdMux = '0;
    if (regAddr == ADDR_W'(TPR_OFS)) rdMux = REG_W'(tprReg);
    if (regAddr == ADDR_W'(SVR_OFS)) rdMux = REG_W'(svrReg);
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (regAddr == ADDR_W'(ISR_OFS + w*ISR_STRIDE)) rdMux = isrWord[w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tprReg    <= '0;
      svrReg    <= SVR_BITS'({VEC_W{1'b1}});
      ackDone   <= 1'b0;
      ackVector <= '0;
      regRdData <= '0;
    end else begin
      if (regWrEn && regAddr == ADDR_W'(TPR_OFS)) tprReg <= regWrData[VEC_W-1:0];
      if (regWrEn && regAddr == ADDR_W'(SVR_OFS)) svrReg <= regWrData[SVR_BITS-1:0];
      ackDone <= ackReq;
      if (ackReq) ackVector <= eligible ? hpVec : spurVec;
      if (regRdEn) regRdData <= rdMux;
    end
  end

  // R9
  int_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> svrReg[VEC_W]);
  // R4
  int_above_tpr_chk: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> classOf(hpVec) > tprReg[VEC_W-1 -: CLASS_W]);
  // R6
  spurious_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackReq && !intOut |=> ackDone && ackVector == $past(svrReg[VEC_W-1:0]));
  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |=> ackDone);
endmodule

// File: rtl/vector_priority_arbiter.sv
module vector_priority_arbiter
  import vpa_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [7:0]        reqVector,
  output logic              reqReady,
  output logic              intOut,
  input  logic              ackReq,
  output logic              ackDone,
  output logic [7:0]        ackVector,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData
);
  vpa_strobe_t        strobe;
  vec_t               hpVec, isVec;
  logic               hpValid, isValid;
  logic [NUM_VEC-1:0] isrBits;

  assign reqReady = 1'b1;

  vpa_control #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqVector(reqVector),
    .ackReq(ackReq), .ackDone(ackDone), .ackVector(ackVector), .intOut(intOut),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .hpVec(hpVec), .hpValid(hpValid), .isVec(isVec), .isValid(isValid),
    .isrBits(isrBits), .strobe(strobe)
  );

  vpa_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hpVec(hpVec), .hpValid(hpValid), .isVec(isVec), .isValid(isValid),
    .isrBits(isrBits)
  );
endmodule

// File: tb/vector_priority_arbiter_tb.sv
module vector_priority_arbiter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqVector = '0;
  logic        reqReady, intOut, ackDone;
  logic        ackReq = 1'b0;
  logic [7:0]  ackVector;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  int compared = 0, mismatched = 0;
  bit  finished = 0;

  localparam logic [11:0] TPR = 12'h080, EOI = 12'h0B0, SVR = 12'h0F0;

  always #4 clk = ~clk;

  vector_priority_arbiter u_dut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic regRead(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1; regAddr = a;
    @(negedge clk); regRdEn = 0; d = regRdData;
  endtask

  task automatic pushReq(logic [7:0] v);
    @(negedge clk); reqValid = 1; reqVector = v;
    @(negedge clk); reqValid = 0;
  endtask

  task automatic doAck(string tag, logic [7:0] exp);
    @(negedge clk); ackReq = 1;
    @(negedge clk); ackReq = 0;
    check({tag, " ackDone"}, 32'(ackDone), 1);
    check({tag, " ackVector"}, 32'(ackVector), 32'(exp));
  endtask

  task automatic checkIsr(string tag, int w, logic [31:0] exp);
    logic [31:0] d;
    regRead(12'h100 + 12'(w * 16), d);
    check(tag, d, exp);
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 intOut", 32'(intOut), 0);
    check("R2 reqReady", 32'(reqReady), 1);
    regRead(SVR, d); check("R1 svr", d, 32'h0FF);
    regRead(TPR, d); check("R1 tpr", d, 0);
    for (int w = 0; w < 8; w++) checkIsr("R1 isr word", w, 0);
  endtask

  task automatic testDisabledDrop();
    pushReq(8'h40);
    regWrite(SVR, 32'h1FF);
    check("R2 disabled drop intOut", 32'(intOut), 0);
    doAck("R2 disabled drop", 8'hFF);
    checkIsr("R2 no isr", 2, 0);
  endtask

  task automatic testBasicAndNest();
    pushReq(8'h45);
    check("R3 int raised", 32'(intOut), 1);
    doAck("R5 first", 8'h45);
    check("R5 int low after ack", 32'(intOut), 0);
    checkIsr("R8 word2", 2, 32'h20);
    pushReq(8'h46);
    check("R3 same class blocked", 32'(intOut), 0);
    pushReq(8'h91);
    check("R3 higher class nests", 32'(intOut), 1);
    doAck("R5 nested", 8'h91);
    checkIsr("R8 word4", 4, 32'h0002_0000);
  endtask

  task automatic testEoi();
    regWrite(EOI, 32'h0);
    checkIsr("R7 top cleared", 4, 0);
    checkIsr("R7 lower kept", 2, 32'h20);
    check("R3 still blocked by isr", 32'(intOut), 0);
    regWrite(EOI, 32'hFFFF_FFFF);
    check("R7 pending unmasked", 32'(intOut), 1);
    doAck("R5 third", 8'h46);
    checkIsr("R8 word2 b6", 2, 32'h40);
    regWrite(EOI, 0);
    regWrite(EOI, 0);
    for (int w = 0; w < 8; w++) checkIsr("R7 empty eoi", w, 0);
    check("R7 empty eoi intOut", 32'(intOut), 0);
  endtask

  task automatic testReserved();
    pushReq(8'h1F);
    pushReq(8'h00);
    check("R2 reserved intOut", 32'(intOut), 0);
    doAck("R2 reserved", 8'hFF);
  endtask

  task automatic testTpr();
    logic [31:0] d;
    regWrite(TPR, 32'h5A);
    regRead(TPR, d); check("R4 tpr readback", d, 32'h5A);
    pushReq(8'h55);
    check("R4 equal class blocked", 32'(intOut), 0);
    pushReq(8'h62);
    check("R4 above tpr", 32'(intOut), 1);
    regWrite(TPR, 32'hF0);
    check("R4 class15 blocks", 32'(intOut), 0);
    doAck("R6 tpr15", 8'hFF);
    checkIsr("R6 no isr", 3, 0);
    regWrite(TPR, 0);
    check("R4 released", 32'(intOut), 1);
    doAck("R5 tpr0", 8'h62);
    doAck("R6 lower class", 8'hFF);
    regWrite(EOI, 0);
    doAck("R5 class5", 8'h55);
    regWrite(EOI, 0);
  endtask

  task automatic testSameClass();
    pushReq(8'h73);
    pushReq(8'h7A);
    doAck("R5 highest in class", 8'h7A);
    check("R3 same class after ack", 32'(intOut), 0);
    regWrite(EOI, 0);
    doAck("R5 remaining", 8'h73);
    regWrite(EOI, 0);
  endtask

  task automatic testSvr();
    logic [31:0] d;
    regWrite(SVR, 32'hFFFF_F33F);
    regRead(SVR, d); check("R9 svr readback", d, 32'h33F);
    doAck("R6 programmed spurious", 8'h3F);
    pushReq(8'h80);
    check("R9 enabled int", 32'(intOut), 1);
    regWrite(SVR, 32'h03F);
    check("R9 disable drops int", 32'(intOut), 0);
    doAck("R9 disabled ack", 8'h3F);
    regWrite(SVR, 32'h13F);
    check("R9 reenable keeps pending", 32'(intOut), 1);
    doAck("R9 kept pending", 8'h80);
    checkIsr("R8 word4 b0", 4, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testDisabledDrop();
    testBasicAndNest();
    testEoi();
    testReserved();
    testTpr();
    testSameClass();
    testSvr();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule